// File: doc/BRIEF.md
# Sequential Signed/Unsigned 32-by-16 Divider

This block divides a 32-bit dividend by a 16-bit divisor over a fixed number of clock cycles. It handles both unsigned and two's-complement operands. A one-cycle start pulse loads the operands and the mode. `busy_o` stays high while the quotient is being formed, and `done_o` pulses once when the packed result and the condition flags are ready. The outputs then hold their values until the next operation completes.

A successful division returns one 32-bit word: the 16-bit remainder in the upper half and the 16-bit quotient in the lower half. A zero divisor and a quotient too wide for 16 bits are reported on separate status outputs. In both of those cases the returned word is the original dividend, so the destination keeps its value. The core runs a restoring shift-subtract loop on operand magnitudes and applies the signs afterward. The enclosing pipeline decides whether to raise an exception.

Top module: `div32x16`

## Requirements
- R1: A start pulse seen while `busy_o` is low is accepted. From the next cycle, `busy_o` is high until the result is ready. `done_o` is a single-cycle pulse visible 18 rising edges after the edge that accepted the start, and `busy_o` is low in that cycle.
- R2: A start pulse while `busy_o` is high is ignored. The running operation completes with its own operands, and no extra completion follows. A start in the cycle where `done_o` is high is accepted.
- R3: In unsigned mode (`signed_i`=0) with a quotient that fits, `result_o[31:16]` is the remainder and `result_o[15:0]` is the quotient of the unsigned division.
- R4: In signed mode (`signed_i`=1) the divisor is sign-extended from 16 bits. The quotient truncates toward zero, and the remainder takes the sign of the dividend, packed as in R3.
- R5: `flag_c_o` is 0 at every completion.
- R6: A zero divisor gives `div_zero_o`=1, `overflow_o`=0, `flag_n_o`=`flag_z_o`=`flag_v_o`=0, and `result_o` equal to the dividend.
- R7: In unsigned mode a quotient of 65536 or more gives `overflow_o`=1, `flag_v_o`=1, `flag_n_o`=`flag_z_o`=0, and `result_o` equal to the dividend.
- R8: In signed mode a quotient outside -32768..32767 is an overflow reported as in R7. A quotient of exactly -32768 is a success.
- R9: On success, `flag_v_o`=0, `flag_z_o`=1 exactly when the 16-bit quotient is zero, `flag_n_o` equals quotient bit 15, and `div_zero_o`=`overflow_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled when not busy |
| signed_i | input | 1 | 1 selects two's-complement division |
| dividend_i | input | 32 | Dividend, also the value returned when the division fails |
| divisor_i | input | 16 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Remainder in 31:16 and quotient in 15:0, or the dividend on failure |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag, always 0 |
| div_zero_o | output | 1 | Divisor was zero |
| overflow_o | output | 1 | Quotient did not fit in 16 bits |

## Verification
Two events can fall on the same edge: the completion of one division and the arrival of the next start. The bench drives a new start in the very cycle it sees `done_o`. It then judges that the new operation is accepted, that its own result and latency are correct, and that the first operation's result was already reported intact. A related collision, a start while `busy_o` is high, is provoked in the middle of a run with different operands. It passes if the original result is returned and no extra completion appears afterwards.

// File: rtl/div_pkg.sv
package div_pkg;

    localparam int DVS_W  = 16;
    localparam int DVD_W  = 2 * DVS_W;
    localparam int ITER   = DVS_W + 1;
    localparam int CNT_W  = $clog2(ITER + 1);

    // Operand information prepared at start and held for the whole run
    typedef struct packed {
        logic [DVD_W-1:0] orig;       // untouched dividend, returned on failure
        logic [DVD_W-1:0] dvd_mag;    // dividend magnitude
        logic [DVS_W-1:0] dvs_mag;    // divisor magnitude
        logic             q_neg;      // quotient is negative
        logic             r_neg;      // remainder is negative
        logic             is_signed;
        logic             dvs_zero;
        logic             early_ovf;  // quotient cannot fit ITER bits
    } op_ctx_t;

    typedef struct packed {
        logic [DVD_W-1:0] word;
        logic             n;
        logic             z;
        logic             v;
        logic             c;
        logic             dz;
        logic             ovf;
    } div_res_t;

    function automatic logic [DVS_W-1:0] cond_neg16(input logic [DVS_W-1:0] x,
                                                    input logic en);
        return en ? (~x + 1'b1) : x;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
#(
    parameter int W_DVS = DVS_W,
    parameter int W_DVD = DVD_W,
    parameter int N_IT  = ITER
) (
    input  logic             signed_i,
    input  logic [W_DVD-1:0] dividend_i,
    input  logic [W_DVS-1:0] divisor_i,
    output op_ctx_t          ctx_o
);
    localparam int TOP_W = W_DVD - N_IT;

    logic             dvd_sgn;
    logic             dvs_sgn;
    logic [W_DVD-1:0] dvd_mag;
    logic [W_DVS-1:0] dvs_mag;
    logic [TOP_W-1:0] dvd_top;

    always_comb begin
        dvd_sgn = signed_i & dividend_i[W_DVD-1];
        dvs_sgn = signed_i & divisor_i[W_DVS-1];
        dvd_mag = dvd_sgn ? (~dividend_i + 1'b1) : dividend_i;
        dvs_mag = dvs_sgn ? (~divisor_i + 1'b1) : divisor_i;
        dvd_top = dvd_mag[W_DVD-1:N_IT];

        ctx_o           = '0;
        ctx_o.orig      = dividend_i;
        ctx_o.dvd_mag   = dvd_mag;
        ctx_o.dvs_mag   = dvs_mag;
        ctx_o.q_neg     = dvd_sgn ^ dvs_sgn;
        ctx_o.r_neg     = dvd_sgn;
        ctx_o.is_signed = signed_i;
        ctx_o.dvs_zero  = (divisor_i == '0);
        // quotient < 2^ITER iff the bits above ITER are below the divisor
        ctx_o.early_ovf = ({1'b0, dvd_top} >= dvs_mag);
    end
endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
    parameter int W_DVS = 16,
    parameter int N_IT  = 17,
    parameter int W_CNT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [W_DVS-1:0] rem_init_i,
    input  logic [N_IT-1:0]  bits_i,
    input  logic [W_DVS-1:0] dvs_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic [N_IT-1:0]  quot_o,
    output logic [W_DVS-1:0] rem_o
);
    localparam logic [W_CNT-1:0] LAST = W_CNT'(N_IT - 1);

    logic             busy_q;
    logic             fin_q;
    logic [W_CNT-1:0] cnt_q;
    logic [W_DVS-1:0] rem_q;
    logic [W_DVS-1:0] dvs_q;
    logic [N_IT-1:0]  sh_q;
    logic [N_IT-1:0]  q_q;

    logic [W_DVS:0]   trial;
    logic [W_DVS:0]   diff;
    logic             take;

    always_comb begin
        trial = {rem_q, sh_q[N_IT-1]};
        diff  = trial - {1'b0, dvs_q};
        take  = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            sh_q   <= '0;
            q_q    <= '0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                rem_q  <= rem_init_i;
                dvs_q  <= dvs_i;
                sh_q   <= bits_i;
                q_q    <= '0;
            end else if (busy_q) begin
                rem_q <= take ? diff[W_DVS-1:0] : trial[W_DVS-1:0];
                sh_q  <= {sh_q[N_IT-2:0], 1'b0};
                q_q   <= {q_q[N_IT-2:0], take};
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign fin_o  = fin_q;
    assign quot_o = q_q;
    assign rem_o  = rem_q;

    // A running step sequence advances by one each cycle and is never restarted
    assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

    assert_finish_once_R1: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> !busy_q);
endmodule

// File: rtl/div_result_pack.sv
module div_result_pack
    import div_pkg::*;
#(
    parameter int W_DVS = DVS_W,
    parameter int N_IT  = ITER
) (
    input  op_ctx_t          ctx_i,
    input  logic [N_IT-1:0]  quot_i,
    input  logic [W_DVS-1:0] rem_i,
    output div_res_t         res_o
);
    logic [W_DVS-1:0] q_lo;
    logic [W_DVS-1:0] q_fin;
    logic [W_DVS-1:0] r_fin;
    logic             fits;

    always_comb begin
        q_lo  = quot_i[W_DVS-1:0];
        q_fin = cond_neg16(q_lo, ctx_i.q_neg);
        r_fin = cond_neg16(rem_i, ctx_i.r_neg);

        if (!ctx_i.is_signed)
            fits = !quot_i[N_IT-1];
        else if (ctx_i.q_neg)
            fits = !quot_i[N_IT-1] &&
                   (!q_lo[W_DVS-1] || (q_lo[W_DVS-2:0] == '0));
        else
            fits = !quot_i[N_IT-1] && !q_lo[W_DVS-1];
        fits = fits && !ctx_i.early_ovf;

        res_o = '0;
        if (ctx_i.dvs_zero) begin
            res_o.word = ctx_i.orig;
            res_o.dz   = 1'b1;
        end else if (!fits) begin
            res_o.word = ctx_i.orig;
            res_o.v    = 1'b1;
            res_o.ovf  = 1'b1;
        end else begin
            res_o.word = {r_fin, q_fin};
            res_o.z    = (q_fin == '0);
            res_o.n    = q_fin[W_DVS-1];
        end
        res_o.c = 1'b0;
    end
endmodule

// File: rtl/div32x16.sv
module div32x16
    import div_pkg::*;
#(
    parameter int W_DVS = DVS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  signed_i,
    input  logic [2*W_DVS-1:0]    dividend_i,
    input  logic [W_DVS-1:0]      divisor_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [2*W_DVS-1:0]    result_o,
    output logic                  flag_n_o,
    output logic                  flag_z_o,
    output logic                  flag_v_o,
    output logic                  flag_c_o,
    output logic                  div_zero_o,
    output logic                  overflow_o
);
    localparam int W_DVD = 2 * W_DVS;
    localparam int N_IT  = W_DVS + 1;
    localparam int W_CNT = $clog2(N_IT + 1);

    op_ctx_t          ctx_now;
    op_ctx_t          ctx_q;
    div_res_t         res_now;
    div_res_t         res_q;
    logic             core_busy;
    logic             core_fin;
    logic [N_IT-1:0]  quot;
    logic [W_DVS-1:0] rem;
    logic             accept;
    logic             done_q;

    assign busy_o = core_busy | core_fin;
    assign accept = start_i & ~busy_o;

    div_operand_prep #(.W_DVS(W_DVS), .W_DVD(W_DVD), .N_IT(N_IT)) u_prep (
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .ctx_o      (ctx_now)
    );

    div_restoring_core #(.W_DVS(W_DVS), .N_IT(N_IT), .W_CNT(W_CNT)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .rem_init_i (W_DVS'(ctx_now.dvd_mag >> N_IT)),
        .bits_i     (ctx_now.dvd_mag[N_IT-1:0]),
        .dvs_i      (ctx_now.dvs_mag),
        .busy_o     (core_busy),
        .fin_o      (core_fin),
        .quot_o     (quot),
        .rem_o      (rem)
    );

    div_result_pack #(.W_DVS(W_DVS), .N_IT(N_IT)) u_pack (
        .ctx_i  (ctx_q),
        .quot_i (quot),
        .rem_i  (rem),
        .res_o  (res_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= core_fin;
            if (accept)
                ctx_q <= ctx_now;
            if (core_fin)
                res_q <= res_now;
        end
    end

    assign done_o     = done_q;
    assign result_o   = res_q.word;
    assign flag_n_o   = res_q.n;
    assign flag_z_o   = res_q.z;
    assign flag_v_o   = res_q.v;
    assign flag_c_o   = res_q.c;
    assign div_zero_o = res_q.dz;
    assign overflow_o = res_q.ovf;

    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o);

    assert_carry_clear_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !flag_c_o);

    assert_div0_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && div_zero_o) |->
            (!flag_n_o && !flag_z_o && !flag_v_o && !overflow_o && result_o == ctx_q.orig));

    assert_no_overflow_dest_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && overflow_o) |->
            (flag_v_o && !flag_n_o && !flag_z_o && !div_zero_o && result_o == ctx_q.orig));

    assert_success_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !overflow_o && !div_zero_o) |->
            (!flag_v_o && flag_z_o == (result_o[W_DVS-1:0] == '0) && flag_n_o == result_o[W_DVS-1]));
endmodule

// File: tb/div32x16_test.sv
module div32x16_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [15:0] divisor_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o, div_zero_o, overflow_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    div32x16 uut (
        .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
        .flag_c_o(flag_c_o), .div_zero_o(div_zero_o), .overflow_o(overflow_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: returns word and flag vector {n,z,v,c,dz,ovf}
    task automatic model(input logic [31:0] dvd, input logic [15:0] dvs, input bit sgn,
                         output logic [31:0] w, output logic [5:0] f);
        longint q, r;
        if (dvs == 16'd0) begin
            w = dvd; f = 6'b000010;
            return;
        end
        if (sgn) begin
            q = longint'($signed(dvd)) / longint'($signed(dvs));
            r = longint'($signed(dvd)) % longint'($signed(dvs));
            if (q < -32768 || q > 32767) begin
                w = dvd; f = 6'b001001; return;
            end
        end else begin
            q = longint'({32'd0, dvd}) / longint'({48'd0, dvs});
            r = longint'({32'd0, dvd}) % longint'({48'd0, dvs});
            if (q > 65535) begin
                w = dvd; f = 6'b001001; return;
            end
        end
        w = {r[15:0], q[15:0]};
        f = {q[15], (q[15:0] == 16'd0), 4'b0000};
    endtask

    task automatic issue(input logic [31:0] dvd, input logic [15:0] dvs, input bit sgn);
        start_i = 1'b1; dividend_i = dvd; divisor_i = dvs; signed_i = sgn;
        @(negedge clk);
        start_i = 1'b0; dividend_i = $urandom; divisor_i = 16'($urandom);
    endtask

    // Called at a negedge after issue(); waits for done and checks everything
    task automatic finish_and_check(input logic [31:0] dvd, input logic [15:0] dvs,
                                    input bit sgn, input string req);
        logic [31:0] ew; logic [5:0] ef; int n;
        n = 0;
        chk(busy_o == 1'b1, "R1 busy after start", 64'(busy_o), 64'd1);
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        model(dvd, dvs, sgn, ew, ef);
        chk(n == 18, "R1 latency", 64'(n), 64'd18);
        chk(busy_o == 1'b0, "R1 idle at done", 64'(busy_o), 64'd0);
        chk(result_o == ew, req, 64'(result_o), 64'(ew));
        chk({flag_n_o, flag_z_o, flag_v_o, flag_c_o, div_zero_o, overflow_o} == ef,
            {req, " flags R9 R5"},
            64'({flag_n_o, flag_z_o, flag_v_o, flag_c_o, div_zero_o, overflow_o}), 64'(ef));
    endtask

    task automatic run(input logic [31:0] dvd, input logic [15:0] dvs, input bit sgn,
                       input string req);
        issue(dvd, dvs, sgn);
        finish_and_check(dvd, dvs, sgn, req);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] a; logic [15:0] b; bit s; int k;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk({busy_o, done_o, result_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o,
             div_zero_o, overflow_o} == '0, "R1 reset state",
            64'({busy_o, done_o, result_o}), 64'd0);

        // directed unsigned cases (R3)
        run(32'd100, 16'd7, 1'b0, "R3 100/7");
        run(32'h0000_0005, 16'd10, 1'b0, "R3 zero quotient");
        run(32'hFFFE_FFFF, 16'hFFFF, 1'b0, "R3 max fitting");
        // unsigned overflow (R7)
        run(32'h0001_0000, 16'd1, 1'b0, "R7 q=65536");
        run(32'hFFFF_FFFF, 16'hFFFF, 1'b0, "R7 large");
        // divide by zero (R6), both modes
        run(32'h1234_5678, 16'd0, 1'b0, "R6 unsigned zero divisor");
        run(32'h8765_4321, 16'd0, 1'b1, "R6 signed zero divisor");
        // signed cases (R4)
        run(32'hFFFF_FF9C, 16'd7, 1'b1, "R4 -100/7");
        run(32'd100, 16'hFFF9, 1'b1, "R4 100/-7");
        run(32'hFFFF_FF9C, 16'hFFF9, 1'b1, "R4 -100/-7");
        // signed boundaries (R8)
        run(32'hFFFF_8000, 16'd1, 1'b1, "R8 q=-32768 fits");
        run(32'h0000_8000, 16'd1, 1'b1, "R8 q=32768 overflow");
        run(32'h8000_0000, 16'hFFFF, 1'b1, "R8 min/-1 overflow");
        run(32'h0000_7FFF, 16'd1, 1'b1, "R8 q=32767 fits");

        // start while busy is ignored (R2)
        issue(32'd1000, 16'd3, 1'b0);
        repeat (5) @(negedge clk);
        start_i = 1'b1; dividend_i = 32'd9; divisor_i = 16'd2; signed_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        begin
            logic [31:0] ew; logic [5:0] ef; int extra;
            while (!done_o) @(negedge clk);
            model(32'd1000, 16'd3, 1'b0, ew, ef);
            chk(result_o == ew, "R2 busy start ignored", 64'(result_o), 64'(ew));
            extra = 0;
            repeat (25) begin
                @(negedge clk);
                if (done_o || busy_o) extra++;
            end
            chk(extra == 0, "R2 no extra completion", 64'(extra), 64'd0);
        end

        // back-to-back: start in the done cycle (R2)
        issue(32'd777, 16'd10, 1'b0);
        while (!done_o) @(negedge clk);
        begin
            logic [31:0] ew; logic [5:0] ef;
            model(32'd777, 16'd10, 1'b0, ew, ef);
            chk(result_o == ew, "R2 first of pair", 64'(result_o), 64'(ew));
        end
        issue(32'hFFFF_FC00, 16'd9, 1'b1);
        finish_and_check(32'hFFFF_FC00, 16'd9, 1'b1, "R2 start at done accepted R4");
        @(negedge clk);

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            s = 1'($urandom);
            k = $urandom_range(0, 9);
            b = 16'($urandom);
            if (k == 0) b = 16'd0;
            else if (k < 3) b = 16'($urandom_range(1, 15));
            if (k < 6) begin
                a = $urandom;
            end else begin
                a = 32'(b) * 32'($urandom_range(0, 32767)) + 32'($urandom_range(0, 15));
                if (s && $urandom_range(0, 1) == 1) a = ~a + 1'b1;
            end
            run(a, b, s, s ? "R4 R8 random signed" : "R3 R7 random unsigned");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule